// File: doc/BRIEF.md
# Asynchronous External Memory Bus Sequencer

This block runs accesses to one chip-select region of an external parallel memory in asynchronous mode. The region can hold static RAM, ferroelectric RAM, pseudo-static RAM or NOR flash. A requester gives address, write data, byte enables and a direction flag through a valid/ready handshake. The sequencer then steps through a fixed series of timed phases. It drives the active-low chip select, output enable, write enable and byte-lane strobes, the address bus and the data bus direction. For reads it returns the captured data with a one-cycle valid pulse.

Each phase length comes from its own programmed cycle count. A phase whose count is N lasts N+1 clock cycles. A zero count therefore gives one cycle, and no phase is ever skipped. Writes can use their own set of counts. For NOR and pseudo-static types the address can also go out on the shared data bus during an extra hold phase. An external wait line can stretch the data phase, and its polarity is programmable. Configuration inputs are expected to stay stable while an access is in progress.

Top module: `extbus_async_seq`

## Requirements
- R1: An accepted access runs lane setup, address setup, (address hold), data setup, data hold and turnaround in that order. Each phase lasts its programmed count plus one cycles, and a count of zero gives one cycle.
- R2: The byte-lane strobes go low for the enabled lanes (`memBlN[i]` low when `reqBe[i]` is 1) `cfgLaneSetup`+1 cycles before `memCsN` goes low. They stay low until data hold ends. `memCsN` is low from address setup to the end of data hold.
- R3: With `cfgMuxEn`=1 and a kind of PSRAM (1) or NOR (2 or 3), an address hold phase follows address setup. During address setup and address hold, `memDataOut` carries address bits 15:0 and `memDataOe` is 1.
- R4: With kind SRAM/FRAM (`cfgMemKind`=0), `cfgMuxEn` has no effect: there is no address hold phase and the data bus is not driven with the address.
- R5: With `cfgSplitWr`=1, writes take address setup, address hold, data setup, data hold and turnaround from the `cfgWr*` inputs. Reads always use the `cfgRd*` inputs. With `cfgSplitWr`=0, writes also use the `cfgRd*` inputs.
- R6: With `cfgWide`=1 the bus is 16 bits. With `cfgWide`=0 only bits 7:0 carry data, `memBlN[1]` stays high, the high write byte is driven as zero and the high read byte is returned as zero.
- R7: With `cfgAsyncWaitEn`=1, each cycle of data setup in which `memWait` equals `cfgWaitHigh` (wait active low when `cfgWaitHigh`=0) adds one cycle to the phase. With `cfgAsyncWaitEn`=0 the wait input is ignored.
- R8: Read data is sampled from `memDataIn` in the last cycle of data setup. `rdValid` is high for exactly the first cycle of data hold, with the sampled value on `rdData`.
- R9: `reqReady` is high only while idle. It is low from the cycle after acceptance through the last turnaround cycle.
- R10: `memOeN` is low only during data setup of a read, and `memWeN` only during data setup of a write. Write data is driven (`memDataOe`=1) during data setup and data hold of a write. The bus is never driven while `memOeN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables, active high |
| rdValid | output | 1 | One-cycle read data valid |
| rdData | output | DATA_W | Captured read data |
| cfgMemKind | input | 2 | 0 SRAM/FRAM, 1 PSRAM, 2/3 NOR |
| cfgWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfgMuxEn | input | 1 | Request address/data multiplexing |
| cfgSplitWr | input | 1 | Use write timing set for writes |
| cfgAsyncWaitEn | input | 1 | Honour wait input |
| cfgWaitHigh | input | 1 | Wait active level is high |
| cfgLaneSetup | input | CNT_W | Lane setup count |
| cfgRdAddrSetup | input | CNT_W | Read-set address setup count |
| cfgRdAddrHold | input | CNT_W | Read-set address hold count |
| cfgRdDataSetup | input | CNT_W | Read-set data setup count |
| cfgRdDataHold | input | CNT_W | Read-set data hold count |
| cfgRdTurn | input | CNT_W | Read-set turnaround count |
| cfgWrAddrSetup | input | CNT_W | Write-set address setup count |
| cfgWrAddrHold | input | CNT_W | Write-set address hold count |
| cfgWrDataSetup | input | CNT_W | Write-set data setup count |
| cfgWrDataHold | input | CNT_W | Write-set data hold count |
| cfgWrTurn | input | CNT_W | Write-set turnaround count |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memBlN | output | DATA_W/8 | Byte-lane strobes, active low |
| memAddr | output | ADDR_W | Address bus |
| memDataOut | output | DATA_W | Data bus drive value |
| memDataOe | output | 1 | Data bus drive enable |
| memDataIn | input | DATA_W | Data bus sampled value |
| memWait | input | 1 | External wait line |

## Verification
Reads and writes are run with distinct counts per phase, so that a swapped or off-by-one phase shows up in the cycle it occurs. Split and shared write timing are both exercised, and so are mux requests for SRAM and NOR kinds, which separates the mux gating from the phase logic. Wait is driven at both polarities, with the enable both on and off. That shows whether stretching follows the level and the enable and nothing else. Read data on the bus is correct only in the final data setup cycle, so a capture one cycle early or late returns the wrong value. An all-zero timing set checks the one-cycle minimum of each phase.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LANE = 3'd1,
    PH_ASET = 3'd2,
    PH_AHLD = 3'd3,
    PH_DSET = 3'd4,
    PH_DHLD = 3'd5,
    PH_TURN = 3'd6
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic capture;
    logic laneAct;
    logic selAct;
    logic rdAct;
    logic wrAct;
    logic drvAddr;
    logic drvData;
  } strobe_t;

  localparam logic [1:0] KIND_SRAM = 2'd0;

  // index into a timing set
  localparam int T_ASET = 0;
  localparam int T_AHLD = 1;
  localparam int T_DSET = 2;
  localparam int T_DHLD = 3;
  localparam int T_TURN = 4;
  localparam int T_NUM  = 5;

endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       cfgMemKind,
  input  logic             cfgMuxEn,
  input  logic             cfgSplitWr,
  input  logic             cfgAsyncWaitEn,
  input  logic             cfgWaitHigh,
  input  logic             memWait,
  input  logic [CNT_W-1:0] cfgLaneSetup,
  input  logic [CNT_W-1:0] rdSet [T_NUM],
  input  logic [CNT_W-1:0] wrSet [T_NUM],
  output logic             reqReady,
  output strobe_t          stb
);

  phase_e           phase, phaseNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             wrQ;
  logic             useWr;
  logic             waitActive;
  logic             muxActive;
  logic             lastCyc;
  logic             latchReq, capture;
  logic [CNT_W-1:0] actSet [T_NUM];

  assign useWr      = wrQ && cfgSplitWr;
  assign waitActive = cfgAsyncWaitEn && (memWait == cfgWaitHigh);
  assign muxActive  = cfgMuxEn && (cfgMemKind != KIND_SRAM);
  assign lastCyc    = (cnt == '0);

  for (genvar i = 0; i < T_NUM; i++) begin : g_sel
    assign actSet[i] = useWr ? wrSet[i] : rdSet[i];
  end

  always_comb begin
    phaseNx  = phase;
    cntNx    = lastCyc ? cnt : cnt - CNT_W'(1);
    latchReq = 1'b0;
    capture  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        cntNx = cnt;
        if (reqValid) begin
          phaseNx  = PH_LANE;
          cntNx    = cfgLaneSetup;
          latchReq = 1'b1;
        end
      end
      PH_LANE: if (lastCyc) begin
        phaseNx = PH_ASET;
        cntNx   = actSet[T_ASET];
      end
      PH_ASET: if (lastCyc) begin
        if (muxActive) begin
          phaseNx = PH_AHLD;
          cntNx   = actSet[T_AHLD];
        end else begin
          phaseNx = PH_DSET;
          cntNx   = actSet[T_DSET];
        end
      end
      PH_AHLD: if (lastCyc) begin
        phaseNx = PH_DSET;
        cntNx   = actSet[T_DSET];
      end
      PH_DSET: begin
        if (waitActive) begin
          cntNx = cnt;
        end else if (lastCyc) begin
          phaseNx = PH_DHLD;
          cntNx   = actSet[T_DHLD];
          capture = !wrQ;
        end
      end
      PH_DHLD: if (lastCyc) begin
        phaseNx = PH_TURN;
        cntNx   = actSet[T_TURN];
      end
      PH_TURN: if (lastCyc) begin
        phaseNx = PH_IDLE;
      end
      default: phaseNx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      wrQ   <= 1'b0;
    end else begin
      phase <= phaseNx;
      cnt   <= cntNx;
      if (latchReq) wrQ <= reqWrite;
    end
  end

  assign reqReady     = (phase == PH_IDLE);
  assign stb.latchReq = latchReq;
  assign stb.capture  = capture;
  assign stb.laneAct  = (phase == PH_LANE) || (phase == PH_ASET) || (phase == PH_AHLD) ||
                        (phase == PH_DSET) || (phase == PH_DHLD);
  assign stb.selAct   = (phase == PH_ASET) || (phase == PH_AHLD) ||
                        (phase == PH_DSET) || (phase == PH_DHLD);
  assign stb.rdAct    = (phase == PH_DSET) && !wrQ;
  assign stb.wrAct    = (phase == PH_DSET) && wrQ;
  assign stb.drvAddr  = muxActive && ((phase == PH_ASET) || (phase == PH_AHLD));
  assign stb.drvData  = wrQ && ((phase == PH_DSET) || (phase == PH_DHLD));

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DSET && waitActive) |=> (phase == PH_DSET)); // R7

  AST_SRAM_NO_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_AHLD) |-> (cfgMemKind != KIND_SRAM)); // R4

  AST_READY_AFTER_TURN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> ($past(phase) == PH_TURN)); // R9

  AST_HOLD_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DHLD && $past(phase) != PH_DHLD) |-> ($past(phase) == PH_DSET)); // R1

endmodule

// File: rtl/extbus_datapath.sv
module extbus_datapath
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              cfgWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W/8-1:0] memBlN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe
);

  localparam int LANES  = DATA_W / 8;
  localparam int HALF   = DATA_W / 2;
  localparam int HALF_L = LANES / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rdValidQ;
  logic [LANES-1:0]  laneMask;
  logic [DATA_W-1:0] wrBus;
  logic [DATA_W-1:0] rdBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      rdataQ   <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (stb.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
      end
      if (stb.capture) rdataQ <= rdBus;
      rdValidQ <= stb.capture;
    end
  end

  always_comb begin
    if (cfgWide) begin
      laneMask = beQ;
      wrBus    = wdataQ;
      rdBus    = memDataIn;
    end else begin
      laneMask = {{(LANES-HALF_L){1'b0}}, beQ[HALF_L-1:0]};
      wrBus    = {{HALF{1'b0}}, wdataQ[HALF-1:0]};
      rdBus    = {{HALF{1'b0}}, memDataIn[HALF-1:0]};
    end
  end

  assign memBlN     = stb.laneAct ? ~laneMask : '1;
  assign memCsN     = !stb.selAct;
  assign memOeN     = !stb.rdAct;
  assign memWeN     = !stb.wrAct;
  assign memAddr    = addrQ;
  assign memDataOut = stb.drvAddr ? addrQ[DATA_W-1:0] : wrBus;
  assign memDataOe  = stb.drvAddr || stb.drvData;
  assign rdValid    = rdValidQ;
  assign rdData     = rdataQ;

  AST_LANES_LEAD_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCsN) |-> $past(stb.laneAct)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R10

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe); // R10

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R8

endmodule

// File: rtl/extbus_async_seq.sv
module extbus_async_seq
  import extbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  input  logic [1:0]          cfgMemKind,
  input  logic                cfgWide,
  input  logic                cfgMuxEn,
  input  logic                cfgSplitWr,
  input  logic                cfgAsyncWaitEn,
  input  logic                cfgWaitHigh,
  input  logic [CNT_W-1:0]    cfgLaneSetup,
  input  logic [CNT_W-1:0]    cfgRdAddrSetup,
  input  logic [CNT_W-1:0]    cfgRdAddrHold,
  input  logic [CNT_W-1:0]    cfgRdDataSetup,
  input  logic [CNT_W-1:0]    cfgRdDataHold,
  input  logic [CNT_W-1:0]    cfgRdTurn,
  input  logic [CNT_W-1:0]    cfgWrAddrSetup,
  input  logic [CNT_W-1:0]    cfgWrAddrHold,
  input  logic [CNT_W-1:0]    cfgWrDataSetup,
  input  logic [CNT_W-1:0]    cfgWrDataHold,
  input  logic [CNT_W-1:0]    cfgWrTurn,
  output logic                memCsN,
  output logic                memOeN,
  output logic                memWeN,
  output logic [DATA_W/8-1:0] memBlN,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memDataOut,
  output logic                memDataOe,
  input  logic [DATA_W-1:0]   memDataIn,
  input  logic                memWait
);

  strobe_t          stb;
  logic [CNT_W-1:0] rdSet [T_NUM];
  logic [CNT_W-1:0] wrSet [T_NUM];

  assign rdSet[T_ASET] = cfgRdAddrSetup;
  assign rdSet[T_AHLD] = cfgRdAddrHold;
  assign rdSet[T_DSET] = cfgRdDataSetup;
  assign rdSet[T_DHLD] = cfgRdDataHold;
  assign rdSet[T_TURN] = cfgRdTurn;
  assign wrSet[T_ASET] = cfgWrAddrSetup;
  assign wrSet[T_AHLD] = cfgWrAddrHold;
  assign wrSet[T_DSET] = cfgWrDataSetup;
  assign wrSet[T_DHLD] = cfgWrDataHold;
  assign wrSet[T_TURN] = cfgWrTurn;

  extbus_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .cfgMemKind(cfgMemKind), .cfgMuxEn(cfgMuxEn), .cfgSplitWr(cfgSplitWr),
    .cfgAsyncWaitEn(cfgAsyncWaitEn), .cfgWaitHigh(cfgWaitHigh), .memWait(memWait),
    .cfgLaneSetup(cfgLaneSetup), .rdSet(rdSet), .wrSet(wrSet),
    .reqReady(reqReady), .stb(stb)
  );

  extbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWide(cfgWide),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .memDataIn(memDataIn),
    .rdValid(rdValid), .rdData(rdData), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .memBlN(memBlN), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe)
  );

endmodule

// File: tb/extbus_async_seq_tb_top.sv
module extbus_async_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        rdValid;
  logic [15:0] rdData;
  logic [1:0]  cfgMemKind = 2'd0;
  logic        cfgWide = 1'b1, cfgMuxEn = 1'b0, cfgSplitWr = 1'b0;
  logic        cfgAsyncWaitEn = 1'b0, cfgWaitHigh = 1'b0;
  logic [3:0]  tLane = '0;
  logic [3:0]  rAs = '0, rAh = '0, rDs = '0, rDh = '0, rTu = '0;
  logic [3:0]  wAs = '0, wAh = '0, wDs = '0, wDh = '0, wTu = '0;
  logic        memCsN, memOeN, memWeN, memDataOe;
  logic [1:0]  memBlN;
  logic [19:0] memAddr;
  logic [15:0] memDataOut;
  logic [15:0] memDataIn = 16'h5A5A;
  logic        memWait = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic        ready, cs, oe, we, dOe, rdv, waitLvl;
    logic [1:0]  bl;
    logic [15:0] dout, rdat, din;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [19:0] curAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  extbus_async_seq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData), .cfgMemKind(cfgMemKind), .cfgWide(cfgWide),
    .cfgMuxEn(cfgMuxEn), .cfgSplitWr(cfgSplitWr), .cfgAsyncWaitEn(cfgAsyncWaitEn),
    .cfgWaitHigh(cfgWaitHigh), .cfgLaneSetup(tLane),
    .cfgRdAddrSetup(rAs), .cfgRdAddrHold(rAh), .cfgRdDataSetup(rDs),
    .cfgRdDataHold(rDh), .cfgRdTurn(rTu),
    .cfgWrAddrSetup(wAs), .cfgWrAddrHold(wAh), .cfgWrDataSetup(wDs),
    .cfgWrDataHold(wDh), .cfgWrTurn(wTu),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memBlN(memBlN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .memDataIn(memDataIn), .memWait(memWait)
  );

  function automatic exp_t baseEntry(string tag);
    exp_t e;
    e.ready = 1'b0; e.cs = 1'b1; e.oe = 1'b1; e.we = 1'b1; e.dOe = 1'b0;
    e.rdv = 1'b0; e.waitLvl = !cfgWaitHigh; e.bl = 2'b11;
    e.dout = '0; e.rdat = '0; e.din = 16'h5A5A; e.tag = tag;
    return e;
  endfunction

  task automatic checkEntry(input exp_t e, input bit busy);
    logic [7:0] act, exq;
    act = {reqReady, memCsN, memOeN, memWeN, memBlN, memDataOe, rdValid};
    exq = {e.ready, e.cs, e.oe, e.we, e.bl, e.dOe, e.rdv};
    checks++;
    if (act !== exq) begin
      errors++;
      $display("FAIL %s ctl {rdy,cs,oe,we,bl,doe,rdv} act=%b exp=%b t=%0t", e.tag, act, exq, $time);
    end
    if (e.dOe) begin
      checks++;
      if (memDataOut !== e.dout) begin
        errors++;
        $display("FAIL %s dataOut act=%h exp=%h t=%0t", e.tag, memDataOut, e.dout, $time);
      end
    end
    if (e.rdv) begin
      checks++;
      if (rdData !== e.rdat) begin
        errors++;
        $display("FAIL %s rdData act=%h exp=%h t=%0t", e.tag, rdData, e.rdat, $time);
      end
    end
    if (busy) begin
      checks++;
      if (memAddr !== curAddr) begin
        errors++;
        $display("FAIL %s addr act=%h exp=%h t=%0t", e.tag, memAddr, curAddr, $time);
      end
    end
  endtask

  // builds the expected per-cycle trace of one access from the requirements
  task automatic runTx(input bit wr, input logic [19:0] addr, input logic [15:0] wd,
                       input logic [1:0] be, input logic [15:0] rv, input int k,
                       input string tag);
    exp_t e, idl;
    bit   mux;
    int   as, ah, ds, dh, tu, dlen;
    logic [1:0]  blAct;
    logic [15:0] wdOut, rdExp;
    @(negedge clk);
    idl = baseEntry(tag); idl.ready = 1'b1;
    checkEntry(idl, 1'b0);
    mux   = cfgMuxEn && (cfgMemKind != 2'd0);
    blAct = cfgWide ? ~be : {1'b1, ~be[0]};
    wdOut = cfgWide ? wd : {8'h00, wd[7:0]};
    rdExp = cfgWide ? rv : {8'h00, rv[7:0]};
    if (wr && cfgSplitWr) begin as = wAs; ah = wAh; ds = wDs; dh = wDh; tu = wTu; end
    else begin as = rAs; ah = rAh; ds = rDs; dh = rDh; tu = rTu; end
    for (int i = 0; i <= int'(tLane); i++) begin
      e = baseEntry(tag); e.bl = blAct; expQ.push_back(e);
    end
    for (int i = 0; i <= as; i++) begin
      e = baseEntry(tag); e.cs = 1'b0; e.bl = blAct; e.dOe = mux; e.dout = addr[15:0];
      expQ.push_back(e);
    end
    if (mux) for (int i = 0; i <= ah; i++) begin
      e = baseEntry(tag); e.cs = 1'b0; e.bl = blAct; e.dOe = 1'b1; e.dout = addr[15:0];
      expQ.push_back(e);
    end
    dlen = ds + 1 + (cfgAsyncWaitEn ? k : 0);
    for (int i = 0; i < dlen; i++) begin
      e = baseEntry(tag); e.cs = 1'b0; e.bl = blAct;
      e.oe = wr; e.we = !wr; e.dOe = wr; e.dout = wdOut;
      e.waitLvl = (i < k) ? cfgWaitHigh : !cfgWaitHigh;
      e.din = (i == dlen - 1) ? rv : ~rv;
      expQ.push_back(e);
    end
    for (int i = 0; i <= dh; i++) begin
      e = baseEntry(tag); e.cs = 1'b0; e.bl = blAct; e.dOe = wr; e.dout = wdOut;
      e.rdv = (i == 0) && !wr; e.rdat = rdExp;
      expQ.push_back(e);
    end
    for (int i = 0; i <= tu; i++) begin
      e = baseEntry(tag); expQ.push_back(e);
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd; reqBe = be;
    curAddr = addr;
    while (expQ.size() > 0) begin
      @(negedge clk);
      reqValid = 1'b0;
      e = expQ.pop_front();
      checkEntry(e, 1'b1);
      memWait = e.waitLvl;
      memDataIn = e.din;
    end
    memWait = !cfgWaitHigh;
  endtask

  task automatic setRd(input logic [3:0] ln, as, ah, ds, dh, tu);
    tLane = ln; rAs = as; rAh = ah; rDs = ds; rDh = dh; rTu = tu;
  endtask

  task automatic setWr(input logic [3:0] as, ah, ds, dh, tu);
    wAs = as; wAh = ah; wDs = ds; wDh = dh; wTu = tu;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    exp_t idl;
    repeat (3) @(negedge clk);
    // reset state, R9 ready high while idle
    idl = baseEntry("R9"); idl.ready = 1'b1;
    checkEntry(idl, 1'b0);
    rstN = 1'b1;
    setRd(4'd1, 4'd2, 4'd1, 4'd3, 4'd1, 4'd2);
    setWr(4'd3, 4'd2, 4'd4, 4'd2, 4'd1);
    // R1 R2 R8 R9 read on static RAM, 16-bit
    runTx(1'b0, 20'h1_2345, 16'h0000, 2'b11, 16'hBEEF, 0, "R1");
    // R10 R2 write with shared timing, only upper lane
    runTx(1'b1, 20'h0_0ABC, 16'hC0DE, 2'b10, 16'h0000, 0, "R10");
    // R5 split write timing
    cfgSplitWr = 1'b1;
    runTx(1'b1, 20'h3_1111, 16'h7E57, 2'b11, 16'h0000, 0, "R5");
    runTx(1'b0, 20'h3_2222, 16'h0000, 2'b01, 16'h1234, 0, "R5");
    cfgSplitWr = 1'b0;
    // R3 mux on NOR, read and write
    cfgMemKind = 2'd2; cfgMuxEn = 1'b1;
    runTx(1'b0, 20'hF_A5C3, 16'h0000, 2'b11, 16'h4321, 0, "R3");
    runTx(1'b1, 20'h0_5A3C, 16'h9876, 2'b11, 16'h0000, 0, "R3");
    cfgMemKind = 2'd1;
    runTx(1'b0, 20'h2_0F0F, 16'h0000, 2'b11, 16'h1357, 0, "R3");
    // R4 mux requested on SRAM kind is ignored
    cfgMemKind = 2'd0;
    runTx(1'b0, 20'hA_BCDE, 16'h0000, 2'b11, 16'h2468, 0, "R4");
    runTx(1'b1, 20'h1_BCDE, 16'h5555, 2'b11, 16'h0000, 0, "R4");
    cfgMuxEn = 1'b0;
    // R6 8-bit bus
    cfgWide = 1'b0;
    runTx(1'b0, 20'h0_0011, 16'h0000, 2'b11, 16'hA9C7, 0, "R6");
    runTx(1'b1, 20'h0_0012, 16'hFF3C, 2'b11, 16'h0000, 0, "R6");
    cfgWide = 1'b1;
    // R7 wait active low, enabled, stretches data setup
    cfgAsyncWaitEn = 1'b1; cfgWaitHigh = 1'b0; memWait = 1'b1;
    runTx(1'b0, 20'h4_0000, 16'h0000, 2'b11, 16'h6A6A, 3, "R7");
    // R7 wait active high on a write
    cfgWaitHigh = 1'b1; memWait = 1'b0;
    runTx(1'b1, 20'h4_0002, 16'h3C3C, 2'b11, 16'h0000, 2, "R7");
    // R7 wait ignored when disabled
    cfgAsyncWaitEn = 1'b0;
    runTx(1'b0, 20'h4_0004, 16'h0000, 2'b11, 16'h0F1E, 2, "R7");
    cfgWaitHigh = 1'b0; memWait = 1'b1;
    // R1 all-zero counts: each phase one cycle, with mux on NOR
    setRd(4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0);
    runTx(1'b0, 20'h5_5555, 16'h0000, 2'b11, 16'hD00D, 0, "R1");
    cfgMemKind = 2'd3; cfgMuxEn = 1'b1;
    runTx(1'b1, 20'h5_AAAA, 16'h1F2E, 2'b01, 16'h0000, 0, "R1");
    cfgMuxEn = 1'b0;
    // R8 back-to-back reads with distinct data
    setRd(4'd2, 4'd1, 4'd0, 4'd2, 4'd0, 4'd1);
    runTx(1'b0, 20'h6_0001, 16'h0000, 2'b11, 16'h0101, 0, "R8");
    runTx(1'b0, 20'h6_0002, 16'h0000, 2'b11, 16'hFEFE, 0, "R8");
    @(negedge clk);
    idl = baseEntry("R9"); idl.ready = 1'b1;
    checkEntry(idl, 1'b0);
    finish();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    finish();
  end

endmodule